// File: doc/BRIEF.md
# Codec Serial Host Port Controller

This block is the master end of the synchronous serial link between a voice-band codec and its host processor. It runs the shift clock at the master clock rate, counts out frames of a fixed number of master clock cycles, and issues a one-cycle frame-sync pulse just before each word. In every frame it sends one 16-bit word MSB first, either the ADC sample or register read data. At the same time it receives one 16-bit word, which carries either a DAC sample or a control command.

Two mode pins select one of three modes. In software mode the least significant bit of each received word marks it as a sample or as a request for a control exchange. In hardware data mode every word is a full 16-bit sample. In hardware control mode every frame carries a sample and a control exchange. A control exchange adds a second frame-sync pulse at mid-frame, followed by a second word in each direction. The control word either writes a small bank of 12-bit registers or selects the register whose contents go out in the next exchange. In software mode the port goes back to plain data operation at the end of each frame.

Top module: `codec_host_port`

## Requirements
- R1: `sclk_o` is a copy of `clk_i`. A frame lasts OSR clock cycles. Frame cycles are numbered 0 to OSR-1. `fs_o` is high only in cycle OSR-1, plus cycle OSR/2-1 of a frame that has a control exchange.
- R2: In cycles 0 to 15, `tx_o` carries the `adc_i` value captured at the end of the previous frame's last cycle, MSB first (bit 15 in cycle 0). `tx_o` changes on the rising edge. Outside the word windows `tx_o` is 0. `rx_i` is sampled on the falling edge in the same cycles.
- R3: With mode pins 00, a primary word whose bit 0 is 0 is a sample. `dac_o` becomes the word with bit 0 cleared, and `dac_vld_o` is high for exactly cycle 17 of the frame.
- R4: With mode pins 00, a primary word whose bit 0 is 1 leaves `dac_o` unchanged and raises no `dac_vld_o`. It starts a control exchange: a second sync in cycle OSR/2-1 and a second word in cycles OSR/2 to OSR/2+15.
- R5: With mode pins 01, all 16 received bits, bit 0 included, go to `dac_o` with a `dac_vld_o` pulse. No control exchange takes place, and a word driven in the mid-frame window changes no register.
- R6: With mode pins 1x, all 16 received bits go to `dac_o`, and every frame carries a control exchange.
- R7: In a control word, bit 15 = 1 means a write: bits 14:12 give the register address and bits 11:0 the value. Register n appears on `regs_o[12n+11:12n]` before the frame ends.
- R8: A control word with bit 15 = 0 selects register bits 14:12 for reading. In the next control exchange, the secondary transmit word is {4'b0, register value}, MSB first. After reset register 0 is selected.
- R9: In software mode a control exchange lasts one frame. The next frame, if its bit 0 is 0, has no second sync and carries no control word.
- R10: The mode pins are captured only at the end of each frame's last cycle. A change during a frame has no effect on that frame.
- R11: While reset is low, `fs_o`, `tx_o`, `dac_vld_o`, `dac_o` and `regs_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode pins: 00 software, 01 hardware data, 1x hardware control |
| adc_i | input | 16 | ADC sample, captured at frame start |
| rx_i | input | 1 | Serial data from host |
| sclk_o | output | 1 | Shift clock |
| fs_o | output | 1 | Frame-sync pulse (primary and secondary) |
| tx_o | output | 1 | Serial data to host |
| dac_o | output | 16 | Last DAC sample received |
| dac_vld_o | output | 1 | One-cycle pulse when `dac_o` is updated |
| regs_o | output | 96 | Control register bank, 8 x 12 bits |

## Verification
The bench builds the port with OSR = 40, so a frame is 40 cycles and the mid-frame window begins at cycle 20. With frames this short, every cycle of every frame can be checked in each mode-pin combination. The bench writes all eight control registers and reads each one back through the delayed read path. It also runs the software-mode return to data operation and mode-pin changes in the middle of a frame.

// File: rtl/csp_pkg.sv
package csp_pkg;

  typedef enum logic [1:0] {
    MODE_SW     = 2'b00,
    MODE_HWDATA = 2'b01,
    MODE_HWCTRL = 2'b10
  } csp_mode_e;

  // Pins 1x both mean hardware control.
  function automatic csp_mode_e csp_decode(input logic [1:0] pins);
    if (pins[1]) return MODE_HWCTRL;
    else if (pins[0]) return MODE_HWDATA;
    else return MODE_SW;
  endfunction

endpackage

// File: rtl/csp_rst_sync.sv
module csp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/csp_frame_timer.sv
// Frame cycle counter and window decode. Needs OSR >= 2*W + 4.
module csp_frame_timer #(
  parameter int OSR = 256,
  parameter int W   = 16,
  localparam int CW = $clog2(OSR),
  localparam int PW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          sec_en_i,
  output logic          frame_end_o,
  output logic          prim_done_o,
  output logic          sec_done_o,
  output logic          prim_win_o,
  output logic          sec_win_o,
  output logic [PW-1:0] pos_o,
  output logic          fs_o
);
  localparam logic [CW-1:0] LAST_C   = CW'(OSR - 1);
  localparam logic [CW-1:0] WEND_C   = CW'(W);
  localparam logic [CW-1:0] HALF_C   = CW'(OSR / 2);
  localparam logic [CW-1:0] HALFM1_C = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] SEND_C   = CW'(OSR / 2 + W);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST_C) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    frame_end_o = (cnt_q == LAST_C);
    prim_done_o = (cnt_q == WEND_C);
    sec_done_o  = sec_en_i && (cnt_q == SEND_C);
    prim_win_o  = (cnt_q < WEND_C);
    sec_win_o   = sec_en_i && (cnt_q >= HALF_C) && (cnt_q < SEND_C);
    if (prim_win_o) pos_o = PW'(cnt_q);
    else            pos_o = PW'(cnt_q - HALF_C);
    fs_o = frame_end_o || (sec_en_i && (cnt_q == HALFM1_C));
  end
endmodule

// File: rtl/csp_serdes.sv
// Transmit bit select (rising-edge timed) and falling-edge receive shifter.
module csp_serdes #(
  parameter int W = 16,
  localparam int PW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          prim_win_i,
  input  logic          sec_win_i,
  input  logic [PW-1:0] pos_i,
  input  logic [W-1:0]  prim_word_i,
  input  logic [W-1:0]  sec_word_i,
  input  logic          rx_i,
  output logic          tx_o,
  output logic [W-1:0]  rx_word_o
);
  localparam logic [PW-1:0] TOP_C = PW'(W - 1);

  logic [PW-1:0] idx;
  logic [W-1:0]  rx_q, rx_d;

  always_comb begin
    idx = TOP_C - pos_i;
    if (prim_win_i)     tx_o = prim_word_i[idx];
    else if (sec_win_i) tx_o = sec_word_i[idx];
    else                tx_o = 1'b0;
  end

  always_comb begin
    if (prim_win_i || sec_win_i) rx_d = {rx_q[W-2:0], rx_i};
    else                         rx_d = rx_q;
  end

  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign rx_word_o = rx_q;
endmodule

// File: rtl/csp_frame_ctrl.sv
// Mode capture, sample/control classification, DAC register.
module csp_frame_ctrl
  import csp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         frame_end_i,
  input  logic         prim_done_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] adc_i,
  input  logic [W-1:0] rx_word_i,
  output csp_mode_e    mode_o,
  output logic         sec_o,
  output logic [W-1:0] adc_o,
  output logic [W-1:0] dac_o,
  output logic         dac_vld_o
);
  csp_mode_e    mode_q, mode_d;
  logic         sec_q, sec_d;
  logic [W-1:0] adc_q, adc_d;
  logic [W-1:0] dac_q, dac_d;
  logic         vld_q, vld_d;

  always_comb begin
    mode_d = mode_q;
    adc_d  = adc_q;
    sec_d  = sec_q;
    dac_d  = dac_q;
    vld_d  = 1'b0;
    if (frame_end_i) begin
      mode_d = csp_decode(mode_i);
      adc_d  = adc_i;
      sec_d  = 1'b0;
    end
    if (prim_done_i) begin
      unique case (mode_q)
        MODE_SW: begin
          if (rx_word_i[0]) begin
            sec_d = 1'b1;
          end else begin
            dac_d = {rx_word_i[W-1:1], 1'b0};
            vld_d = 1'b1;
          end
        end
        MODE_HWDATA: begin
          dac_d = rx_word_i;
          vld_d = 1'b1;
        end
        default: begin
          dac_d = rx_word_i;
          vld_d = 1'b1;
          sec_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SW;
      sec_q  <= 1'b0;
      adc_q  <= '0;
      dac_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sec_q  <= sec_d;
      adc_q  <= adc_d;
      dac_q  <= dac_d;
      vld_q  <= vld_d;
    end
  end

  assign mode_o    = mode_q;
  assign sec_o     = sec_q;
  assign adc_o     = adc_q;
  assign dac_o     = dac_q;
  assign dac_vld_o = vld_q;
endmodule

// File: rtl/csp_ctrl_bank.sv
// Control register bank: write command or read-address select.
module csp_ctrl_bank #(
  parameter int W      = 16,
  parameter int ADDR_W = 3,
  localparam int NREG  = 1 << ADDR_W,
  localparam int DW    = W - 1 - ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             cmd_vld_i,
  input  logic [W-1:0]     cmd_i,
  output logic             we_o,
  output logic [W-1:0]     rd_word_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic              is_wr;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     wdata;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic [DW-1:0]     reg_q [NREG];
  logic [DW-1:0]     reg_d [NREG];

  always_comb begin
    is_wr = cmd_i[W-1];
    addr  = cmd_i[W-2 -: ADDR_W];
    wdata = cmd_i[DW-1:0];
    we_o  = cmd_vld_i && is_wr;
    if (cmd_vld_i && !is_wr) rd_addr_d = addr;
    else                     rd_addr_d = rd_addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rd_addr_q <= '0;
    else        rd_addr_q <= rd_addr_d;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_comb begin
      if (we_o && (addr == ADDR_W'(i))) reg_d[i] = wdata;
      else                              reg_d[i] = reg_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) reg_q[i] <= '0;
      else        reg_q[i] <= reg_d[i];
    end

    assign regs_o[i*DW +: DW] = reg_q[i];
  end

  assign rd_word_o = {{(W-DW){1'b0}}, reg_q[rd_addr_q]};
endmodule

// File: rtl/codec_host_port.sv
module codec_host_port
  import csp_pkg::*;
#(
  parameter int W      = 16,
  parameter int OSR    = 256,
  parameter int ADDR_W = 3,
  localparam int NREG  = 1 << ADDR_W,
  localparam int DW    = W - 1 - ADDR_W,
  localparam int PW    = $clog2(W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [W-1:0]       adc_i,
  input  logic               rx_i,
  output logic               sclk_o,
  output logic               fs_o,
  output logic               tx_o,
  output logic [W-1:0]       dac_o,
  output logic               dac_vld_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic          rst_n_s;
  logic          frame_end, prim_done, sec_done, prim_win, sec_win;
  logic [PW-1:0] pos;
  logic          sec_q;
  csp_mode_e     mode_q;
  logic [W-1:0]  adc_q, rx_word, rd_word;
  logic          reg_we;

  assign sclk_o = clk_i;

  csp_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  csp_frame_timer #(.OSR(OSR), .W(W)) u_timer (
    .clk_i       (clk_i),
    .rst_n       (rst_n_s),
    .sec_en_i    (sec_q),
    .frame_end_o (frame_end),
    .prim_done_o (prim_done),
    .sec_done_o  (sec_done),
    .prim_win_o  (prim_win),
    .sec_win_o   (sec_win),
    .pos_o       (pos),
    .fs_o        (fs_o)
  );

  csp_serdes #(.W(W)) u_serdes (
    .clk_i       (clk_i),
    .rst_n       (rst_n_s),
    .prim_win_i  (prim_win),
    .sec_win_i   (sec_win),
    .pos_i       (pos),
    .prim_word_i (adc_q),
    .sec_word_i  (rd_word),
    .rx_i        (rx_i),
    .tx_o        (tx_o),
    .rx_word_o   (rx_word)
  );

  csp_frame_ctrl #(.W(W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_n       (rst_n_s),
    .frame_end_i (frame_end),
    .prim_done_i (prim_done),
    .mode_i      (mode_i),
    .adc_i       (adc_i),
    .rx_word_i   (rx_word),
    .mode_o      (mode_q),
    .sec_o       (sec_q),
    .adc_o       (adc_q),
    .dac_o       (dac_o),
    .dac_vld_o   (dac_vld_o)
  );

  csp_ctrl_bank #(.W(W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_n     (rst_n_s),
    .cmd_vld_i (sec_done),
    .cmd_i     (rx_word),
    .we_o      (reg_we),
    .rd_word_o (rd_word),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/csp_port_chk.sv
module csp_port_chk #(
  parameter int RW = 96
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          fs_o,
  input logic          dac_vld_o,
  input logic          dac_lsb,
  input logic [1:0]    mode_q,
  input logic          sec_q,
  input logic          reg_we,
  input logic [RW-1:0] regs_o
);
  // R1: each sync pulse lasts one cycle
  assert_fs_single_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    fs_o |=> !fs_o);

  // R3: sample strobe lasts one cycle
  assert_vld_single_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    dac_vld_o |=> !dac_vld_o);

  // R3: software-mode sample has its flag bit cleared
  assert_sw_lsb_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dac_vld_o && mode_q == 2'b00) |-> !dac_lsb);

  // R5: hardware data mode never opens a control exchange
  assert_hwdata_nosec_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_q == 2'b01) |-> !sec_q);

  // R6: hardware control mode pairs each sample with an exchange
  assert_hwctrl_sec_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dac_vld_o && mode_q == 2'b10) |-> sec_q);

  // R7: registers only move on a write command
  assert_regs_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !reg_we |=> $stable(regs_o));
endmodule

bind codec_host_port csp_port_chk #(.RW(NREG*DW)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_s),
  .fs_o      (fs_o),
  .dac_vld_o (dac_vld_o),
  .dac_lsb   (dac_o[0]),
  .mode_q    (mode_q),
  .sec_q     (sec_q),
  .reg_we    (reg_we),
  .regs_o    (regs_o)
);

// File: tb/codec_host_port_tb_top.sv
module codec_host_port_tb_top;
  localparam int OSR  = 40;
  localparam int W    = 16;
  localparam int HALF = OSR / 2;
  localparam int NR   = 8;
  localparam int DW   = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [1:0]       mode;
  logic [W-1:0]     adc;
  logic             rx;
  logic             sclk, fs, tx, dvld;
  logic [W-1:0]     dac;
  logic [NR*DW-1:0] regs;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mreg [NR];
  int            mrd;
  logic [W-1:0]  mdac;

  codec_host_port #(.W(W), .OSR(OSR), .ADDR_W(3)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .adc_i     (adc),
    .rx_i      (rx),
    .sclk_o    (sclk),
    .fs_o      (fs),
    .tx_o      (tx),
    .dac_o     (dac),
    .dac_vld_o (dvld),
    .regs_o    (regs)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Entered at the falling edge of the last cycle of a frame; leaves at the same point of the next.
  task automatic frame(input logic [1:0] md, input logic [W-1:0] av, input logic [W-1:0] pw,
                       input logic [W-1:0] sw, input bit mid, input logic [1:0] mid_md,
                       input string tag);
    bit           exsec, expvld;
    logic [W-1:0] expdac, exptxs, got_p, got_s;
    int           fsbad, idlebad, vldbad;
    exsec  = md[1] || (md == 2'b00 && pw[0]);
    expvld = !(md == 2'b00 && pw[0]);
    expdac = (md == 2'b00) ? {pw[W-1:1], 1'b0} : pw;
    exptxs = {4'b0, mreg[mrd]};
    fsbad = 0; idlebad = 0; vldbad = 0;
    got_p = '0; got_s = '0;
    mode = md;
    adc  = av;
    for (int k = 0; k < OSR; k++) begin
      @(posedge clk);
      #1;
      if (k < W) rx = pw[W-1-k];
      else if (k >= HALF && k < HALF + W) rx = sw[W-1-(k-HALF)];
      else rx = 1'b0;
      if (mid && k == 3) mode = mid_md;
      @(negedge clk);
      if (fs !== ((k == OSR-1) || (exsec && k == HALF-1))) fsbad++;
      if (k < W) got_p[W-1-k] = tx;
      else if (exsec && k >= HALF && k < HALF + W) got_s[W-1-(k-HALF)] = tx;
      else if (tx !== 1'b0) idlebad++;
      if (k == W + 1) begin
        chk(tag, "dac_vld", dvld, expvld);
        if (expvld) chk(tag, "dac", dac, expdac);
      end else if (dvld !== 1'b0) vldbad++;
    end
    chk(tag, "fs pattern", fsbad, 0);
    chk(tag, "tx primary", got_p, av);
    chk(tag, "tx idle", idlebad, 0);
    chk(tag, "stray dac_vld", vldbad, 0);
    if (exsec) chk(tag, "tx readback", got_s, exptxs);
    if (expvld) mdac = expdac;
    chk(tag, "dac hold", dac, mdac);
    if (exsec) begin
      if (sw[15]) mreg[sw[14:12]] = sw[11:0];
      else        mrd = int'(sw[14:12]);
    end
    for (int i = 0; i < NR; i++)
      chk(tag, $sformatf("reg%0d", i), regs[i*DW +: DW], mreg[i]);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) mreg[i] = '0;
    mrd = 0; mdac = '0;
    rst_n = 1'b0; mode = 2'b00; adc = '0; rx = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", "fs", fs, 0);
    chk("R11", "tx", tx, 0);
    chk("R11", "dac_vld", dvld, 0);
    chk("R11", "dac", dac, 0);
    chk("R11", "regs", (regs == '0), 1);
    // R1: shift clock follows master clock
    chk("R1", "sclk low", sclk, 0);
    @(posedge clk);
    #1;
    chk("R1", "sclk high", sclk, 1);
    rst_n = 1'b1;
    do @(negedge clk); while (fs !== 1'b1);

    // R2: transmit patterns, software data frames
    for (int i = 0; i < 6; i++)
      frame(2'b00, 16'h8001 ^ W'(i * 16'h1357), W'((i * 16'h2B6A) ^ 16'hC3C2) & 16'hFFFE,
            16'hFFFF, 0, 2'b00, "R2");
    // R3: software samples with flag 0
    for (int i = 0; i < 4; i++)
      frame(2'b00, W'(i * 16'h0F0F), W'(16'h7FFE - i * 16'h1110), 16'h0000, 0, 2'b00, "R3");
    // R4: software control request writes register 5
    frame(2'b00, 16'h1234, 16'h1235, {1'b1, 3'd5, 12'hABC}, 0, 2'b00, "R4");
    // R9: back to data; mid-frame write must be ignored
    frame(2'b00, 16'h4321, 16'h0F0E, {1'b1, 3'd6, 12'h777}, 0, 2'b00, "R9");
    // R5: hardware data mode, odd words keep bit 0, no control
    for (int i = 0; i < 3; i++)
      frame(2'b01, W'(16'hC001 + i), W'(16'h8003 + i * 16'h0202), {1'b1, 3'(i), 12'hFFF},
            0, 2'b00, "R5");
    // R7: write every register in hardware control mode
    for (int a = 0; a < NR; a++)
      frame(2'b10, W'(a), W'(16'h0101 * a + 1), {1'b1, 3'(a), 12'((a * 12'h123) ^ 12'h05A)},
            0, 2'b00, "R7");
    // R8: read every register back, pins 11
    for (int a = 0; a < NR; a++)
      frame(2'b11, W'(16'hA000 + a), 16'h5555, {1'b0, 3'(a), 12'hFFF}, 0, 2'b00, "R8");
    frame(2'b11, 16'hBEEF, 16'h5554, {1'b0, 3'd0, 12'h000}, 0, 2'b00, "R8");
    // R6: control mode, odd sample goes to DAC intact
    frame(2'b10, 16'h0F0F, 16'hFFFF, {1'b0, 3'd2, 12'h000}, 0, 2'b00, "R6");
    // R10: mode pins changed mid-frame have no effect
    frame(2'b01, 16'h3C3C, 16'h9999, {1'b1, 3'd3, 12'h111}, 1, 2'b10, "R10");
    frame(2'b00, 16'hC3C3, 16'h6666, {1'b1, 3'd4, 12'h222}, 1, 2'b11, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule